// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit converts a logical address, made of a 16-bit segment value or selector together with an offset, into a linear address. It serves one request per strobe and can accept a new request on every cycle. The mode input chooses between two translation paths.

In real mode the segment is scaled by sixteen and added to the low 16 bits of the offset. An address-line-20 enable decides whether the carry into bit 20 survives. In protected mode the selector input is not used. The caller supplies the already-fetched 64-bit segment descriptor. The unit decodes the base, the limit and the attribute bits from that descriptor, scales the limit by the granularity flag, and checks every byte of the access against the segment bounds. Expand-up and expand-down segments are both supported. On success it adds the offset to the base. On failure it reports a not-present fault or a general protection fault and produces no address.

Fetching descriptor tables, privilege comparison and paging are done by neighbouring blocks.

Top module: `seg_xlate`

## Requirements
- R1: Results are registered. A request sampled on one rising edge drives `lin_addr_o` and exactly one of `valid_o`, `np_fault_o`, `gp_fault_o` from that edge until the next one. In a cycle that follows no request, all three strobes are low.
- R2: In real mode (`prot_mode_i`=0), with A20 enabled, the linear address is `seg_i`×16 + `offset_i[15:0]`. Offset bits 31:16 have no effect. Real-mode requests never fault.
- R3: In real mode with `a20_en_i`=0, bit 20 of the result is forced to zero, which means the result wraps modulo 2^20. Bits 31:21 are always zero in real mode.
- R4: In protected mode the linear address is base + offset modulo 2^32. The base is built as {desc[63:56], desc[39:16]}. `seg_i` has no effect in protected mode.
- R5: The raw limit is {desc[51:48], desc[15:0]}. When the granularity bit desc[55] is 0, the effective limit is the raw limit. When it is 1, the effective limit is (raw << 12) | 0xFFF.
- R6: The access covers the bytes offset through offset+N−1, where N is 1, 2, 4 or 8 for `size_i` = 0, 1, 2, 3. For an expand-up segment, the access is in bounds only when offset+N−1 ≤ effective limit. That sum is computed without wrap.
- R7: A segment is expand-down when its executable bit desc[43] is 0 and its direction bit desc[42] is 1. For such a segment, the access is in bounds only when offset > effective limit and offset+N−1 ≤ the upper bound. The upper bound is 0xFFFF when desc[54]=0 and 0xFFFFFFFF when desc[54]=1.
- R8: For a code segment (desc[43]=1), bit 42 does not select expand-down, and the expand-up check applies.
- R9: A protected request whose present bit desc[47] is 0 raises `np_fault_o` regardless of the bounds. It raises neither `gp_fault_o` nor `valid_o`, and `lin_addr_o` is 0.
- R10: A present descriptor with an out-of-bounds access raises `gp_fault_o` with `valid_o` low and `lin_addr_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe, one per translation |
| prot_mode_i | input | 1 | 1 = protected path, 0 = real path |
| a20_en_i | input | 1 | Keeps address bit 20 in real mode |
| seg_i | input | 16 | Segment value or selector |
| offset_i | input | 32 | Offset within the segment |
| size_i | input | 2 | Access width code: 1, 2, 4 or 8 bytes |
| desc_i | input | 64 | Cached segment descriptor |
| lin_addr_o | output | 32 | Linear address, 0 on fault |
| valid_o | output | 1 | Translation succeeded |
| np_fault_o | output | 1 | Segment not present |
| gp_fault_o | output | 1 | Bounds violation |

## Verification
The assertions check the following on every cycle:
- the three result strobes never overlap;
- a strobe appears only after a request;
- a real-mode request always yields a valid result with zero upper bits, and bit 20 is zero when A20 is off;
- a clear present bit always yields a not-present fault with a zero address.

Only the bench scenarios can show the correctness of the arithmetic itself. That covers:
- the exact sums and the A20 wrap value;
- base wrap-around;
- the granularity-scaled limits;
- the last-byte edge cases at each limit for expand-up segments, and for expand-down segments with both upper bounds.

// File: rtl/seg_xlate_pkg.sv
// Package: shared widths and the decoded descriptor type for the
// segment translation unit. Assumes a 64-bit descriptor layout.
package seg_xlate_pkg;
    localparam int SEG_W   = 16;
    localparam int OFF_W   = 32;
    localparam int ADDR_W  = 32;
    localparam int REAL_W  = 20;
    localparam int LIM_W   = 20;
    localparam int PAGE_SH = 12;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [OFF_W-1:0]  eff_limit;
        logic              present;
        logic              expand_dn;
        logic              big;
    } seg_desc_t;
endpackage

// File: rtl/seg_desc_decode.sv
// Module: seg_desc_decode
// Extracts base, effective limit and attribute flags from a 64-bit
// segment descriptor. Purely combinational; assumes caller holds desc
// stable during the request cycle.
module seg_desc_decode
    import seg_xlate_pkg::*;
(
    input  logic [63:0] desc_i,
    output seg_desc_t   dec_o
);
    logic [LIM_W-1:0] raw_lim;
    logic             gran;

    // Gather split fields and scale the limit by granularity.
    always_comb begin
        raw_lim         = {desc_i[51:48], desc_i[15:0]};
        gran            = desc_i[55];
        dec_o.base      = {desc_i[63:56], desc_i[39:16]};
        dec_o.present   = desc_i[47];
        dec_o.expand_dn = !desc_i[43] && desc_i[42];
        dec_o.big       = desc_i[54];
        if (gran)
            dec_o.eff_limit = {raw_lim, {PAGE_SH{1'b1}}};
        else
            dec_o.eff_limit = {{(OFF_W-LIM_W){1'b0}}, raw_lim};
    end
endmodule

// File: rtl/seg_real_path.sv
// Module: seg_real_path
// Real-mode shift-and-add with optional bit-20 masking. Assumes a
// 16-bit segment; only the low 16 offset bits take part.
module seg_real_path
    import seg_xlate_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int RW = REAL_W,
    parameter int AW = ADDR_W
) (
    input  logic [SW-1:0] seg_i,
    input  logic [SW-1:0] off_i,
    input  logic          a20_en_i,
    output logic [AW-1:0] addr_o
);
    localparam int SUM_W = RW + 1;
    logic [SUM_W-1:0] sum;

    // Scale segment by 16, add offset, then mask the carry bit if needed.
    always_comb begin
        sum = {1'b0, seg_i, 4'b0000} + {{(SUM_W-SW){1'b0}}, off_i};
        if (!a20_en_i)
            sum[RW] = 1'b0;
        addr_o = {{(AW-SUM_W){1'b0}}, sum};
    end
endmodule

// File: rtl/seg_bound_check.sv
// Module: seg_bound_check
// Checks the first and last byte of an access against an expand-up or
// expand-down segment. Sums are taken one bit wider, so no wrap occurs.
module seg_bound_check
    import seg_xlate_pkg::*;
#(
    parameter int OW = OFF_W
) (
    input  logic [OW-1:0] off_i,
    input  logic [1:0]    size_i,
    input  logic [OW-1:0] eff_limit_i,
    input  logic          expand_dn_i,
    input  logic          big_i,
    output logic          in_bounds_o
);
    localparam int XW = OW + 1;
    logic [XW-1:0] span;
    logic [XW-1:0] last_b;
    logic [XW-1:0] upper;

    // Width code to (bytes - 1).
    always_comb begin
        span = '0;
        for (int k = 0; k < 4; k++)
            if (size_i == k[1:0])
                span = XW'((1 << k) - 1);
    end

    // Bound comparison for both directions.
    always_comb begin
        last_b = {1'b0, off_i} + span;
        upper  = big_i ? {1'b0, {OW{1'b1}}} : XW'(32'h0000_FFFF);
        if (expand_dn_i)
            in_bounds_o = (off_i > eff_limit_i) && (last_b <= upper);
        else
            in_bounds_o = (last_b <= {1'b0, eff_limit_i});
    end
endmodule

// File: rtl/seg_xlate.sv
// Module: seg_xlate (top)
// Selects the real or protected translation path and registers the
// result one cycle after req_i. A fault zeroes the address and
// suppresses valid_o. Assumes desc_i is the descriptor already fetched
// for the selector.
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              prot_mode_i,
    input  logic              a20_en_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [1:0]        size_i,
    input  logic [63:0]       desc_i,
    output logic [ADDR_W-1:0] lin_addr_o,
    output logic              valid_o,
    output logic              np_fault_o,
    output logic              gp_fault_o
);
    seg_desc_t         dec;
    logic [ADDR_W-1:0] real_addr;
    logic [ADDR_W-1:0] prot_addr;
    logic              in_bounds;
    logic              np_n, gp_n, ok_n;
    logic [ADDR_W-1:0] addr_n;

    seg_desc_decode u_dec (
        .desc_i (desc_i),
        .dec_o  (dec)
    );

    seg_real_path #(.SW(SEG_W), .RW(REAL_W), .AW(ADDR_W)) u_real (
        .seg_i    (seg_i),
        .off_i    (offset_i[SEG_W-1:0]),
        .a20_en_i (a20_en_i),
        .addr_o   (real_addr)
    );

    seg_bound_check #(.OW(OFF_W)) u_bound (
        .off_i       (offset_i),
        .size_i      (size_i),
        .eff_limit_i (dec.eff_limit),
        .expand_dn_i (dec.expand_dn),
        .big_i       (dec.big),
        .in_bounds_o (in_bounds)
    );

    // Protected-path sum, wrapping at the address width.
    assign prot_addr = dec.base + ADDR_W'(offset_i);

    // Pick the path and decide fault priority: not-present before bounds.
    always_comb begin
        np_n   = 1'b0;
        gp_n   = 1'b0;
        ok_n   = 1'b0;
        addr_n = '0;
        if (!prot_mode_i) begin
            ok_n   = 1'b1;
            addr_n = real_addr;
        end else if (!dec.present) begin
            np_n = 1'b1;
        end else if (!in_bounds) begin
            gp_n = 1'b1;
        end else begin
            ok_n   = 1'b1;
            addr_n = prot_addr;
        end
    end

    // Register the result strobes; the address holds between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_addr_o <= '0;
            valid_o    <= 1'b0;
            np_fault_o <= 1'b0;
            gp_fault_o <= 1'b0;
        end else begin
            valid_o    <= req_i && ok_n;
            np_fault_o <= req_i && np_n;
            gp_fault_o <= req_i && gp_n;
            if (req_i)
                lin_addr_o <= addr_n;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Module: seg_xlate_chk
// Temporal checks on the translation unit's ports, attached by bind.
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic        prot_mode_i,
    input logic        a20_en_i,
    input logic [63:0] desc_i,
    input logic [31:0] lin_addr_o,
    input logic        valid_o,
    input logic        np_fault_o,
    input logic        gp_fault_o
);
    // R1
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({valid_o, np_fault_o, gp_fault_o}) <= 1);

    // R1
    strobe_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !(valid_o || np_fault_o || gp_fault_o));

    // R2
    real_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !prot_mode_i) |=> (valid_o && lin_addr_o[31:21] == 11'd0));

    // R3
    a20_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !prot_mode_i && !a20_en_i) |=> !lin_addr_o[20]);

    // R9
    not_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && prot_mode_i && !desc_i[47]) |=> (np_fault_o && lin_addr_o == 32'd0));

    // R10
    gp_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault_o |-> (lin_addr_o == 32'd0 && !valid_o));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .prot_mode_i (prot_mode_i),
    .a20_en_i    (a20_en_i),
    .desc_i      (desc_i),
    .lin_addr_o  (lin_addr_o),
    .valid_o     (valid_o),
    .np_fault_o  (np_fault_o),
    .gp_fault_o  (gp_fault_o)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_i = 0;
    logic        prot_mode_i = 0;
    logic        a20_en_i = 0;
    logic [15:0] seg_i = 0;
    logic [31:0] offset_i = 0;
    logic [1:0]  size_i = 0;
    logic [63:0] desc_i = 0;
    logic [31:0] lin_addr_o;
    logic        valid_o, np_fault_o, gp_fault_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .prot_mode_i(prot_mode_i),
        .a20_en_i(a20_en_i), .seg_i(seg_i), .offset_i(offset_i), .size_i(size_i),
        .desc_i(desc_i), .lin_addr_o(lin_addr_o), .valid_o(valid_o),
        .np_fault_o(np_fault_o), .gp_fault_o(gp_fault_o)
    );

    // Build a descriptor from its fields (layout per R4, R5, R7, R9).
    function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                       input bit g, input bit d, input bit x,
                                       input bit c, input bit p);
        logic [63:0] v = '0;
        v[15:0]  = lim[15:0];
        v[51:48] = lim[19:16];
        v[39:16] = base[23:0];
        v[63:56] = base[31:24];
        v[55] = g; v[54] = d; v[43] = x; v[42] = c; v[47] = p;
        v[44] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [34:0] got, input logic [34:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One request; result is sampled on the following falling edge.
    task automatic xlate(input bit pm, input bit a20, input logic [15:0] s,
                         input logic [31:0] off, input logic [1:0] sz, input logic [63:0] d);
        @(negedge clk);
        req_i = 1; prot_mode_i = pm; a20_en_i = a20; seg_i = s;
        offset_i = off; size_i = sz; desc_i = d;
        @(negedge clk);
        req_i = 0;
    endtask

    // Outputs packed as {valid, np, gp, addr}.
    function automatic logic [34:0] res(input bit v, input bit np, input bit gp, input logic [31:0] a);
        return {v, np, gp, a};
    endfunction

    task automatic t_reset;
        chk("R1 reset", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,0,0,0));
    endtask

    task automatic t_real;
        xlate(0, 1, 16'h1234, 32'h0000_0010, 0, '0);
        chk("R2 real sum", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0001_2350));
        xlate(0, 1, 16'h1234, 32'hABCD_0010, 3, '0);
        chk("R2 high offset ignored", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0001_2350));
    endtask

    task automatic t_a20;
        xlate(0, 1, 16'hFFFF, 32'h0000_FFFF, 0, '0);
        chk("R3 a20 on", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0010_FFEF));
        xlate(0, 0, 16'hFFFF, 32'h0000_FFFF, 0, '0);
        chk("R3 a20 wrap", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0000_FFEF));
    endtask

    task automatic t_idle;
        @(negedge clk);
        chk("R1 idle", {valid_o, np_fault_o, gp_fault_o}, 35'd0);
    endtask

    task automatic t_up;
        logic [63:0] d = mk(32'h0010_0000, 20'h00FFF, 0, 1, 0, 0, 1);
        xlate(1, 1, 16'h0010, 32'h0FFF, 0, d);
        chk("R6 last byte at limit", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0010_0FFF));
        xlate(1, 1, 16'h0010, 32'h0FFF, 1, d);
        chk("R10 word crosses limit", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,0,1,0));
        xlate(1, 1, 16'h0010, 32'h0FFE, 1, d);
        chk("R6 word fits", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0010_0FFE));
        xlate(1, 1, 16'hBEEF, 32'h0FFE, 1, d);
        chk("R4 selector ignored", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0010_0FFE));
    endtask

    task automatic t_gran;
        logic [63:0] d = mk(32'h0200_0000, 20'h00001, 1, 1, 0, 0, 1);
        xlate(1, 1, 0, 32'h1FFC, 2, d);
        chk("R5 4K limit top dword", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0200_1FFC));
        xlate(1, 1, 0, 32'h2000, 0, d);
        chk("R5 past scaled limit", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,0,1,0));
        d = mk(32'hFFFF_F000, 20'hFFFFF, 1, 1, 0, 0, 1);
        xlate(1, 1, 0, 32'h2000, 0, d);
        chk("R4 base wrap", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0000_1000));
    endtask

    task automatic t_down;
        logic [63:0] d = mk(32'h0040_0000, 20'h00FFF, 0, 1, 0, 1, 1);
        xlate(1, 1, 0, 32'h0FFF, 0, d);
        chk("R7 at limit faults", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,0,1,0));
        xlate(1, 1, 0, 32'h1000, 0, d);
        chk("R7 above limit", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0040_1000));
        xlate(1, 1, 0, 32'hFFFF_FFFC, 2, d);
        chk("R7 big top dword", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h003F_FFFC));
        xlate(1, 1, 0, 32'hFFFF_FFFD, 2, d);
        chk("R7 big overrun", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,0,1,0));
        d = mk(32'h0040_0000, 20'h00FFF, 0, 0, 0, 1, 1);
        xlate(1, 1, 0, 32'hFFFF, 0, d);
        chk("R7 small top byte", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0040_FFFF));
        xlate(1, 1, 0, 32'hFFFE, 2, d);
        chk("R7 small overrun", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,0,1,0));
        xlate(1, 1, 0, 32'h0001_0000, 0, d);
        chk("R7 small beyond 64K", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,0,1,0));
    endtask

    task automatic t_code;
        logic [63:0] d = mk(32'h0008_0000, 20'h00FFF, 0, 1, 1, 1, 1);
        xlate(1, 1, 0, 32'h0010, 0, d);
        chk("R8 code low offset", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(1,0,0,32'h0008_0010));
        xlate(1, 1, 0, 32'h1000, 0, d);
        chk("R8 code above limit", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,0,1,0));
    endtask

    task automatic t_np;
        logic [63:0] d = mk(32'h0010_0000, 20'h00FFF, 0, 1, 0, 0, 0);
        xlate(1, 1, 0, 32'h0010, 0, d);
        chk("R9 not present", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,1,0,0));
        xlate(1, 1, 0, 32'h5000, 0, d);
        chk("R9 not present beats bounds", res(valid_o, np_fault_o, gp_fault_o, lin_addr_o), res(0,1,0,0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_real();
        t_idle();
        t_a20();
        t_up();
        t_gran();
        t_down();
        t_code();
        t_np();
        t_idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule